// File: doc/BRIEF.md
# Microcoded Accumulator Processor

This block is a small accumulator machine in which every instruction is run as a short routine of micro-operations. The routines live in an on-chip control store. Each clock edge executes exactly one micro-operation. A micro-operation moves a single register, does one memory access, or changes the control-store address. The machine holds a word-addressed data/program memory of 512 words of 32 bits. A program word carries a 16-bit opcode in bits 31:16 and a 16-bit operand in bits 15:0.

To use it, hold reset high and preload the memory through the load port. Then release reset. The core fetches from address 0 and runs until it meets an opcode that has no routine. At that point it raises `halted` and freezes. The accumulator and program counter are always visible on debug outputs.

Top module: `mcode_acc_core`

## Requirements
- R1: While `rst` is high at a clock edge the core clears the accumulator, the program counter, the control-store address and `halted` to zero. Memory contents are left as they are.
- R2: After reset, each instruction begins with a five-step fetch. The fetch then dispatches using the opcode field (bits 31:16) as the control-store start address. The valid opcodes are 10 (add), 20 (subtract), 30 (load), 40 (store), 50 (jump), 60 (jump if accumulator zero) and 70 (load immediate).
- R3: Every instruction that does not jump advances the program counter by exactly one and leaves the accumulator value it would otherwise produce unchanged by that increment.
- R4: Add and subtract combine the accumulator with the memory word at the operand address, modulo 2^32. Each takes 10 steps after the fetch.
- R5: Store writes the accumulator to the memory word at the operand address in 9 steps. Load copies that word into the accumulator in 9 steps.
- R6: Load immediate places the zero-extended 16-bit operand in the accumulator in 6 steps.
- R7: Jump sets the program counter to the operand in 2 steps.
- R8: Jump-if-zero sets the program counter to the operand in 3 steps when the accumulator is zero. Otherwise it advances the program counter by one in 7 steps.
- R9: An opcode with no routine (for example 0 or 25) raises `halted` at the last fetch step. The program counter stays on that word, and `halted`, the accumulator and the program counter stay frozen until reset.
- R10: Memory addresses use only the low 9 bits of an operand, so operand 0x0205 reaches word 5.
- R11: A write through the load port stores `ld_data` at `ld_addr` on the clock edge where `ld_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Memory preload write enable |
| ld_addr | input | 9 | Memory preload word address |
| ld_data | input | 32 | Memory preload data |
| halted | output | 1 | Core has stopped on an opcode without a routine |
| dbg_acc | output | 32 | Accumulator value |
| dbg_pc | output | 16 | Program counter value |

## Verification
Every instruction's result is due after a fixed number of micro-steps. That count is five for the fetch plus the routine length given in the requirements: 10, 10, 9, 9, 2, 3 or 7, and 6. The bench therefore predicts, for each program, the exact clock edge after reset release on which `halted` first appears. It counts edges until then, sampling on the falling edge, and compares the count as well as the final accumulator and program counter. This timing check catches any routine that gains or loses a step. A final idle stretch confirms the outputs stay frozen after the halt.

// File: rtl/mcode_pkg.sv
package mcode_pkg;

    localparam int CS_AW    = 7;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;
    localparam int MEM_DEPTH = 512;
    localparam int MEM_AW   = $clog2(MEM_DEPTH);

    typedef enum logic [4:0] {
        U_HALT,
        U_SAR_PC,
        U_READ,
        U_IR_SDR,
        U_SDR_OPND,
        U_JMP_OPC,
        U_TMPR_ACC,
        U_ACC_PCINC,
        U_PC_ACC,
        U_ACC_TMPR,
        U_TMPR_SDR,
        U_SAR_TMPR,
        U_ACC_ADD,
        U_ACC_SUB,
        U_ACC_SDR,
        U_SDR_ACC,
        U_WRITE,
        U_PC_SDR,
        U_SKIP,
        U_GOTO
    } uop_e;

    typedef struct packed {
        uop_e             op;
        logic [CS_AW-1:0] target;
    } uinstr_t;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_INC
    } alu_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] tmpr;
        logic [WORD_W-1:0] sdr;
        logic [WORD_W-1:0] ir;
        logic [HALF_W-1:0] pc;
        logic [HALF_W-1:0] sar;
        logic [CS_AW-1:0]  csiar;
        logic              halted;
    } core_state_t;

    function automatic logic opcode_has_routine(input logic [HALF_W-1:0] opc);
        return (opc == 16'd10) || (opc == 16'd20) || (opc == 16'd30) ||
               (opc == 16'd40) || (opc == 16'd50) || (opc == 16'd60) ||
               (opc == 16'd70);
    endfunction

endpackage

// File: rtl/mcode_alu.sv
module mcode_alu
    import mcode_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  alu_sel_e     sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_INC: y = a + W'(1);
            default: y = a;
        endcase
    end

    // R4: subtraction must be the inverse of addition modulo 2^W
    always_comb begin
        if (sel == ALU_SUB) begin
            a_r4_sub_inverse: assert (y + b == a);
        end
    end

endmodule

// File: rtl/mcode_ctrl_store.sv
module mcode_ctrl_store
    import mcode_pkg::*;
(
    input  logic [CS_AW-1:0] addr,
    output uinstr_t          word
);

    logic [CS_AW-1:0] hi;
    logic [CS_AW-1:0] lo;

    function automatic uinstr_t mk(input uop_e op, input logic [CS_AW-1:0] tgt);
        uinstr_t u;
        u.op     = op;
        u.target = tgt;
        return u;
    endfunction

    function automatic uop_e inc_step(input logic [CS_AW-1:0] k);
        unique case (k)
            7'd0:    return U_TMPR_ACC;
            7'd1:    return U_ACC_PCINC;
            7'd2:    return U_PC_ACC;
            default: return U_ACC_TMPR;
        endcase
    endfunction

    always_comb begin
        hi   = addr / CS_AW'(10);
        lo   = addr % CS_AW'(10);
        word = mk(U_HALT, '0);
        unique case (hi)
            7'd0: begin
                unique case (lo)
                    7'd0: word = mk(U_SAR_PC, '0);
                    7'd1: word = mk(U_READ, '0);
                    7'd2: word = mk(U_IR_SDR, '0);
                    7'd3: word = mk(U_SDR_OPND, '0);
                    7'd4: word = mk(U_JMP_OPC, '0);
                    default: word = mk(U_HALT, '0);
                endcase
            end
            7'd1, 7'd2: begin
                unique case (lo)
                    7'd4: word = mk(U_TMPR_SDR, '0);
                    7'd5: word = mk(U_SAR_TMPR, '0);
                    7'd6: word = mk(U_READ, '0);
                    7'd7: word = mk(U_TMPR_SDR, '0);
                    7'd8: word = mk((hi == 7'd1) ? U_ACC_ADD : U_ACC_SUB, '0);
                    7'd9: word = mk(U_GOTO, '0);
                    default: word = mk(inc_step(lo), '0);
                endcase
            end
            7'd3: begin
                unique case (lo)
                    7'd4: word = mk(U_TMPR_SDR, '0);
                    7'd5: word = mk(U_SAR_TMPR, '0);
                    7'd6: word = mk(U_READ, '0);
                    7'd7: word = mk(U_ACC_SDR, '0);
                    7'd8: word = mk(U_GOTO, '0);
                    7'd9: word = mk(U_HALT, '0);
                    default: word = mk(inc_step(lo), '0);
                endcase
            end
            7'd4: begin
                unique case (lo)
                    7'd4: word = mk(U_TMPR_SDR, '0);
                    7'd5: word = mk(U_SAR_TMPR, '0);
                    7'd6: word = mk(U_SDR_ACC, '0);
                    7'd7: word = mk(U_WRITE, '0);
                    7'd8: word = mk(U_GOTO, '0);
                    7'd9: word = mk(U_HALT, '0);
                    default: word = mk(inc_step(lo), '0);
                endcase
            end
            7'd5: begin
                if (lo == 7'd0)      word = mk(U_PC_SDR, '0);
                else if (lo == 7'd1) word = mk(U_GOTO, '0);
                else                 word = mk(U_HALT, '0);
            end
            7'd6: begin
                unique case (lo)
                    7'd0: word = mk(U_SKIP, '0);
                    7'd1: word = mk(U_GOTO, CS_AW'(64));
                    7'd2: word = mk(U_PC_SDR, '0);
                    7'd3: word = mk(U_GOTO, '0);
                    7'd4, 7'd5, 7'd6, 7'd7: word = mk(inc_step(lo - CS_AW'(4)), '0);
                    7'd8: word = mk(U_GOTO, '0);
                    default: word = mk(U_HALT, '0);
                endcase
            end
            7'd7: begin
                unique case (lo)
                    7'd4: word = mk(U_ACC_SDR, '0);
                    7'd5: word = mk(U_GOTO, '0);
                    7'd0, 7'd1, 7'd2, 7'd3: word = mk(inc_step(lo), '0);
                    default: word = mk(U_HALT, '0);
                endcase
            end
            default: word = mk(U_HALT, '0);
        endcase
    end

endmodule

// File: rtl/mcode_memory.sv
module mcode_memory #(
    parameter int DEPTH = 512,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [W-1:0]  core_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem_q[ld_addr] <= ld_data;
        end else if (core_we) begin
            mem_q[core_addr] <= core_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/mcode_acc_core.sv
module mcode_acc_core
    import mcode_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_en,
    input  logic [MEM_AW-1:0]   ld_addr,
    input  logic [WORD_W-1:0]   ld_data,
    output logic                halted,
    output logic [WORD_W-1:0]   dbg_acc,
    output logic [HALF_W-1:0]   dbg_pc
);

    core_state_t st_d, st_q;
    uinstr_t     mir_q, cs_word;

    alu_sel_e          alu_sel;
    logic [WORD_W-1:0] alu_a, alu_b, alu_y;
    logic              mem_we;
    logic [WORD_W-1:0] rd_data;

    mcode_alu #(.W(WORD_W)) u_alu (
        .sel (alu_sel),
        .a   (alu_a),
        .b   (alu_b),
        .y   (alu_y)
    );

    mcode_ctrl_store u_cs (
        .addr (st_d.csiar),
        .word (cs_word)
    );

    mcode_memory #(.DEPTH(MEM_DEPTH), .W(WORD_W)) u_mem (
        .clk       (clk),
        .ld_we     (ld_en),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .core_we   (mem_we),
        .core_addr (st_q.sar[MEM_AW-1:0]),
        .core_data (st_q.sdr),
        .rd_addr   (st_q.sar[MEM_AW-1:0]),
        .rd_data   (rd_data)
    );

    always_comb begin
        st_d    = st_q;
        mem_we  = 1'b0;
        alu_sel = ALU_ADD;
        alu_a   = st_q.acc;
        alu_b   = st_q.tmpr;
        if (!st_q.halted) begin
            st_d.csiar = st_q.csiar + CS_AW'(1);
            unique case (mir_q.op)
                U_SAR_PC:    st_d.sar  = st_q.pc;
                U_READ:      st_d.sdr  = rd_data;
                U_IR_SDR:    st_d.ir   = st_q.sdr;
                U_SDR_OPND:  st_d.sdr  = {{(WORD_W-HALF_W){1'b0}}, st_q.ir[HALF_W-1:0]};
                U_JMP_OPC: begin
                    if (opcode_has_routine(st_q.ir[WORD_W-1:HALF_W])) begin
                        st_d.csiar = st_q.ir[HALF_W+CS_AW-1:HALF_W];
                    end else begin
                        st_d.halted = 1'b1;
                        st_d.csiar  = st_q.csiar;
                    end
                end
                U_TMPR_ACC:  st_d.tmpr = st_q.acc;
                U_ACC_PCINC: begin
                    alu_sel   = ALU_INC;
                    alu_a     = {{(WORD_W-HALF_W){1'b0}}, st_q.pc};
                    st_d.acc  = alu_y;
                end
                U_PC_ACC:    st_d.pc   = st_q.acc[HALF_W-1:0];
                U_ACC_TMPR:  st_d.acc  = st_q.tmpr;
                U_TMPR_SDR:  st_d.tmpr = st_q.sdr;
                U_SAR_TMPR:  st_d.sar  = st_q.tmpr[HALF_W-1:0];
                U_ACC_ADD: begin
                    alu_sel  = ALU_ADD;
                    st_d.acc = alu_y;
                end
                U_ACC_SUB: begin
                    alu_sel  = ALU_SUB;
                    st_d.acc = alu_y;
                end
                U_ACC_SDR:   st_d.acc  = st_q.sdr;
                U_SDR_ACC:   st_d.sdr  = st_q.acc;
                U_WRITE:     mem_we    = 1'b1;
                U_PC_SDR:    st_d.pc   = st_q.sdr[HALF_W-1:0];
                U_SKIP:      st_d.csiar = st_q.csiar +
                                 ((st_q.acc == '0) ? CS_AW'(2) : CS_AW'(1));
                U_GOTO:      st_d.csiar = mir_q.target;
                default: begin
                    st_d.halted = 1'b1;
                    st_d.csiar  = st_q.csiar;
                end
            endcase
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q  <= st_d;
        mir_q <= cs_word;
    end

    assign halted  = st_q.halted;
    assign dbg_acc = st_q.acc;
    assign dbg_pc  = st_q.pc;

    // R9: once halted, the flag and the visible state stay frozen
    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (rst)
        st_q.halted |=> (st_q.halted && $stable(st_q.acc) && $stable(st_q.pc)));

    // R2: a dispatch either halts or lands on the first step of a routine
    a_r2_dispatch_entry: assert property (@(posedge clk) disable iff (rst)
        (!st_q.halted && mir_q.op == U_JMP_OPC) |=>
        (st_q.halted || mir_q.op inside {U_TMPR_ACC, U_PC_SDR, U_SKIP}));

    // R3: the program counter step of the increment routine moves it by one
    a_r3_pc_plus_one: assert property (@(posedge clk) disable iff (rst)
        (!st_q.halted && mir_q.op == U_PC_ACC) |=>
        (st_q.pc == $past(st_q.pc) + HALF_W'(1)));

    // R1: the cycle after reset starts at the first fetch step with clean state
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (st_q.csiar == '0 && !st_q.halted && st_q.acc == '0 && st_q.pc == '0));

endmodule

// File: tb/mcode_acc_core_bench.sv
`timescale 1ns/1ps
module mcode_acc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic        halted;
    logic [31:0] dbg_acc;
    logic [15:0] dbg_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mcode_acc_core u_mcode_acc_core (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .halted  (halted),
        .dbg_acc (dbg_acc),
        .dbg_pc  (dbg_pc)
    );

    function automatic logic [31:0] ins(input int op, input int opnd);
        return {op[15:0], opnd[15:0]};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic load(input int addr, input logic [31:0] data);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = addr[8:0];
        ld_data = data;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    // R11: clear memory through the load port while in reset
    task automatic start_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 512; a++) load(a, 32'h0);
    endtask

    // release reset and count edges until halted is seen
    task automatic run(input string req, input int exp_cyc,
                       input logic [31:0] exp_acc, input logic [15:0] exp_pc);
        int cyc;
        cyc = 0;
        @(negedge clk);
        rst = 1'b0;
        while (1) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted || cyc > 3000) break;
        end
        check(req, "steps to halt", cyc, exp_cyc);
        check(req, "acc", dbg_acc, exp_acc);
        check(req, "pc", {16'h0, dbg_pc}, {16'h0, exp_pc});
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "halted after reset", {31'h0, halted}, 32'h0);
        check("R1", "acc after reset", dbg_acc, 32'h0);
        check("R1", "pc after reset", {16'h0, dbg_pc}, 32'h0);
    endtask

    // R4 R6 R3: LDI 5, ADD [100]=7, SUB [101]=20 -> wraps to -8
    task automatic t_arith();
        start_prog();
        load(0, ins(70, 5));
        load(1, ins(10, 100));
        load(2, ins(20, 101));
        load(3, 32'h0);
        load(100, 32'd7);
        load(101, 32'd20);
        run("R4", 46, 32'hFFFF_FFF8, 16'd3);
    endtask

    // R5: store then reload through memory
    task automatic t_store_load();
        start_prog();
        load(0, ins(70, 16'h1234));
        load(1, ins(40, 200));
        load(2, ins(70, 0));
        load(3, ins(30, 200));
        load(4, 32'h0);
        run("R5", 55, 32'h0000_1234, 16'd4);
    endtask

    // R6: immediate operand is zero-extended
    task automatic t_ldi_extend();
        start_prog();
        load(0, ins(70, 16'hFFFF));
        load(1, 32'h0);
        run("R6", 16, 32'h0000_FFFF, 16'd1);
    endtask

    // R7: unconditional jump skips word 1
    task automatic t_jump();
        start_prog();
        load(0, ins(50, 5));
        load(1, ins(70, 1));
        load(5, ins(70, 9));
        load(6, 32'h0);
        run("R7", 23, 32'd9, 16'd6);
    endtask

    // R8: conditional jump taken when acc is zero
    task automatic t_cbr_taken();
        start_prog();
        load(0, ins(70, 0));
        load(1, ins(60, 4));
        load(2, ins(70, 1));
        load(3, 32'h0);
        load(4, ins(70, 3));
        load(5, 32'h0);
        run("R8", 35, 32'd3, 16'd5);
    endtask

    // R8 R3: conditional jump not taken falls through with acc kept
    task automatic t_cbr_not_taken();
        start_prog();
        load(0, ins(70, 2));
        load(1, ins(60, 4));
        load(2, 32'h0);
        load(4, ins(70, 3));
        load(5, 32'h0);
        run("R8", 28, 32'd2, 16'd2);
    endtask

    // R10: operand 0x0205 aliases word 5
    task automatic t_wrap();
        start_prog();
        load(0, ins(70, 16'h55));
        load(1, ins(40, 16'h0205));
        load(2, ins(30, 5));
        load(3, 32'h0);
        run("R10", 44, 32'h55, 16'd3);
    endtask

    // R9: undefined opcode 25 halts at the end of fetch and stays frozen
    task automatic t_undef();
        start_prog();
        load(0, ins(25, 7));
        run("R9", 5, 32'h0, 16'd0);
        repeat (20) @(negedge clk);
        check("R9", "halted held", {31'h0, halted}, 32'h1);
        check("R9", "pc held", {16'h0, dbg_pc}, 32'h0);
        check("R9", "acc held", dbg_acc, 32'h0);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_store_load();
        t_ldi_extend();
        t_jump();
        t_cbr_taken();
        t_cbr_not_taken();
        t_wrap();
        t_undef();
        t_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule